// File: doc/BRIEF.md
# Page-Splitting DMA Word Sequencer

This block carries a buffer of 16-bit words between a local word buffer and system memory for a bus device. A transfer is launched with a bus address, an even byte count and a direction. The sequencer cuts the transfer into chunks that never cross a 512-byte physical page. It obtains each chunk's physical address from an external translation port, then issues memory accesses one at a time. Each access is as wide as the chunk's physical address and length allow.

For each chunk the access width is chosen afresh: single bytes when the physical address or the chunk length is odd, 16-bit words when either has bit 1 set, 32-bit longwords otherwise. Bytes are packed into buffer words by the parity of their position within the whole transfer. When a translation is refused the transfer stops, and the done strobe reports how many bytes were left untransferred.

The memory and translation ports are request/acknowledge streams. A request is the valid signal and the acknowledge is the ready. Once raised, a request and all of its fields hold unchanged until the cycle in which the acknowledge is sampled high, so the far side may stall for any number of cycles. Only one request is outstanding at a time across both ports. The buffer port has no stall: writes take effect at the clock edge and reads are combinational.

Top module: `dma_page_seq`

## Requirements
- R1: On `start` in the idle state, the byte count is latched with bit 0 cleared and the bus address is latched. A `start` while a transfer is running has no effect on it.
- R2: Each chunk begins with a translation request whose virtual address is the start address plus the bytes already moved, modulo 2^BA_W. The chunk length is the smaller of the bytes left in the 512-byte physical page and the bytes left in the transfer.
- R3: A translation answered with `xl_ok`=0 ends the transfer with no further memory access. `done` then reports the untransferred byte count in `residual`.
- R4: A transfer that moves every byte ends with `residual`=0. A latched count of zero ends with `done` and `residual`=0 and makes no translation or memory request.
- R5: If the chunk's physical address or length is odd, the chunk uses byte accesses (`mem_size`=0, data in bits 7:0). A byte at even transfer position p uses the low half (`buf_be`=01) of buffer word p/2, and a byte at odd position p uses the high half (`buf_be`=10).
- R6: Otherwise, if bit 1 of the physical address or of the length is set, the chunk uses 16-bit accesses (`mem_size`=1, data in bits 15:0), one buffer word each.
- R7: Otherwise the chunk uses 32-bit accesses (`mem_size`=2). Buffer word p/2 maps to memory data bits 15:0 and word p/2+1 maps to bits 31:16.
- R8: `mem_req` with `mem_addr`, `mem_size` and `mem_we` holds stable until `mem_ack` is sampled. `mem_req` and `xl_req` are never high together.
- R9: With `dir_wr`=0, memory data is written into the buffer. With `dir_wr`=1, buffer data is written to memory (`mem_we`=1).
- R10: `done` is a single-cycle pulse and is never high together with a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, honoured only when idle |
| dir_wr | input | 1 | 0: memory to buffer, 1: buffer to memory |
| bus_addr | input | BA_W | Starting bus byte address |
| byte_count | input | CNT_W | Transfer length in bytes (bit 0 ignored) |
| done | output | 1 | One-cycle end-of-transfer strobe |
| residual | output | CNT_W | Bytes not transferred, valid with `done` |
| xl_req | output | 1 | Translation request |
| xl_vaddr | output | BA_W | Bus address to translate |
| xl_ack | input | 1 | Translation answer present |
| xl_ok | input | 1 | Translation succeeded |
| xl_paddr | input | PA_W | Translated physical byte address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_size | output | 2 | 0 byte, 1 16-bit, 2 32-bit |
| mem_addr | output | PA_W | Physical byte address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, right-justified, valid with `mem_ack` |
| buf_addr | output | CNT_W-1 | Buffer word index |
| buf_we | output | 1 | Buffer write enable |
| buf_be | output | 2 | Buffer byte-half enables |
| buf_wdata | output | 16 | Buffer write data |
| buf_rdata | input | 16 | Buffer read data for `buf_addr` |

## Verification
The acknowledge that completes the last access of a chunk is also the cycle in which the sequencer decides between finishing and asking for a new translation. Transfers are therefore placed so that a chunk ends at a page edge with bytes still owed, and also exactly at the end of the count. The bench checks that a second translation is requested in the first case and that a clean `done` appears in the second. A `start` pulse is also injected while a transfer is in flight, landing near one of these chunk-end acknowledges. The check is that the running transfer's access counts, data and residual are unchanged by it.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLATE,
    ST_LOAD_LO,
    ST_LOAD_HI,
    ST_ACCESS,
    ST_STORE_HI
  } seq_state_e;
endpackage

// File: rtl/chunk_planner.sv
// Sizes one page chunk and picks its access width from the translated page offset.
module chunk_planner
  import dma_seq_pkg::*;
#(
  parameter int CNT_W   = 17,
  parameter int PG_BITS = 9
) (
  input  logic [PG_BITS-1:0] page_off,
  input  logic [CNT_W-1:0]   remaining,
  output logic [CNT_W-1:0]   len,
  output acc_size_e          size
);
  localparam int PAGE_BYTES = 1 << PG_BITS;

  logic [CNT_W-1:0] room;

  always_comb begin
    room = CNT_W'(PAGE_BYTES) - CNT_W'(page_off);
    len  = (remaining < room) ? remaining : room;
    if (page_off[0] | len[0])      size = SZ_BYTE;
    else if (page_off[1] | len[1]) size = SZ_WORD;
    else                           size = SZ_LONG;
  end
endmodule

// File: rtl/lane_pack.sv
// Moves bytes and half-words between buffer words and right-justified memory lanes.
module lane_pack
  import dma_seq_pkg::*;
(
  input  acc_size_e   size,
  input  logic        odd_pos,
  input  logic [15:0] wd_lo,
  input  logic [15:0] wd_hi,
  input  logic [15:0] rd_low,
  output logic [31:0] wdata,
  output logic [15:0] st_data,
  output logic [1:0]  st_be
);
  always_comb begin
    unique case (size)
      SZ_BYTE: wdata = {24'h0, (odd_pos ? wd_lo[15:8] : wd_lo[7:0])};
      SZ_WORD: wdata = {16'h0, wd_lo};
      default: wdata = {wd_hi, wd_lo};
    endcase
    if (size == SZ_BYTE) begin
      st_data = {rd_low[7:0], rd_low[7:0]};
      st_be   = odd_pos ? 2'b10 : 2'b01;
    end else begin
      st_data = rd_low;
      st_be   = 2'b11;
    end
  end
endmodule

// File: rtl/dma_page_seq.sv
module dma_page_seq
  import dma_seq_pkg::*;
#(
  parameter int BA_W    = 18,
  parameter int PA_W    = 22,
  parameter int CNT_W   = 17,
  parameter int PG_BITS = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir_wr,
  input  logic [BA_W-1:0]    bus_addr,
  input  logic [CNT_W-1:0]   byte_count,
  output logic               done,
  output logic [CNT_W-1:0]   residual,
  output logic               xl_req,
  output logic [BA_W-1:0]    xl_vaddr,
  input  logic               xl_ack,
  input  logic               xl_ok,
  input  logic [PA_W-1:0]    xl_paddr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [1:0]         mem_size,
  output logic [PA_W-1:0]    mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic [CNT_W-2:0]   buf_addr,
  output logic               buf_we,
  output logic [1:0]         buf_be,
  output logic [15:0]        buf_wdata,
  input  logic [15:0]        buf_rdata
);
  localparam int BUF_AW = CNT_W - 1;

  seq_state_e       st_q;
  acc_size_e        size_q, plan_size;
  logic [CNT_W-1:0] cnt_q, pos_q, left_q, resid_q;
  logic [CNT_W-1:0] remaining, plan_len, step, pos_next, left_next;
  logic [BA_W-1:0]  base_q;
  logic [PA_W-1:0]  pa_q;
  logic             dir_q, done_q;
  logic [15:0]      lo_q, hi_q, st_data;
  logic [1:0]       st_be;
  logic [BUF_AW-1:0] buf_idx;
  logic             chunk_end, xfer_end;
  seq_state_e       adv_state;

  chunk_planner #(.CNT_W(CNT_W), .PG_BITS(PG_BITS)) u_plan (
    .page_off (xl_paddr[PG_BITS-1:0]),
    .remaining(remaining),
    .len      (plan_len),
    .size     (plan_size)
  );

  lane_pack u_lanes (
    .size   (size_q),
    .odd_pos(pos_q[0]),
    .wd_lo  (lo_q),
    .wd_hi  (hi_q),
    .rd_low (mem_rdata[15:0]),
    .wdata  (mem_wdata),
    .st_data(st_data),
    .st_be  (st_be)
  );

  always_comb begin
    remaining = cnt_q - pos_q;
    unique case (size_q)
      SZ_BYTE: step = CNT_W'(1);
      SZ_WORD: step = CNT_W'(2);
      default: step = CNT_W'(4);
    endcase
    pos_next  = pos_q + step;
    left_next = left_q - step;
    chunk_end = (left_next == '0);
    xfer_end  = (pos_next == cnt_q);
    if (chunk_end)  adv_state = xfer_end ? ST_IDLE : ST_XLATE;
    else if (dir_q) adv_state = ST_LOAD_LO;
    else            adv_state = ST_ACCESS;
  end

  assign buf_idx   = pos_q[CNT_W-1:1];
  assign buf_addr  = (st_q == ST_LOAD_HI || st_q == ST_STORE_HI) ? buf_idx + 1'b1 : buf_idx;
  assign buf_we    = (st_q == ST_ACCESS && mem_ack && !dir_q) || (st_q == ST_STORE_HI);
  assign buf_wdata = (st_q == ST_STORE_HI) ? hi_q : st_data;
  assign buf_be    = (st_q == ST_STORE_HI) ? 2'b11 : st_be;

  assign xl_req    = (st_q == ST_XLATE);
  assign xl_vaddr  = base_q + BA_W'(pos_q);
  assign mem_req   = (st_q == ST_ACCESS);
  assign mem_we    = dir_q;
  assign mem_size  = size_q;
  assign mem_addr  = pa_q;
  assign done      = done_q;
  assign residual  = resid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      size_q  <= SZ_BYTE;
      cnt_q   <= '0;
      pos_q   <= '0;
      left_q  <= '0;
      resid_q <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          cnt_q  <= {byte_count[CNT_W-1:1], 1'b0};
          base_q <= bus_addr;
          dir_q  <= dir_wr;
          pos_q  <= '0;
          if (byte_count[CNT_W-1:1] == '0) begin
            done_q  <= 1'b1;
            resid_q <= '0;
          end else begin
            st_q <= ST_XLATE;
          end
        end
        ST_XLATE: if (xl_ack) begin
          if (!xl_ok) begin
            done_q  <= 1'b1;
            resid_q <= remaining;
            st_q    <= ST_IDLE;
          end else begin
            pa_q   <= xl_paddr;
            left_q <= plan_len;
            size_q <= plan_size;
            st_q   <= dir_q ? ST_LOAD_LO : ST_ACCESS;
          end
        end
        ST_LOAD_LO: begin
          lo_q <= buf_rdata;
          st_q <= (size_q == SZ_LONG) ? ST_LOAD_HI : ST_ACCESS;
        end
        ST_LOAD_HI: begin
          hi_q <= buf_rdata;
          st_q <= ST_ACCESS;
        end
        default: begin
          if (st_q == ST_ACCESS && !mem_ack) begin
            st_q <= ST_ACCESS;
          end else if (st_q == ST_ACCESS && !dir_q && size_q == SZ_LONG) begin
            hi_q <= mem_rdata[31:16];
            st_q <= ST_STORE_HI;
          end else begin
            pos_q  <= pos_next;
            pa_q   <= pa_q + PA_W'(step);
            left_q <= left_next;
            st_q   <= adv_state;
            if (chunk_end && xfer_end) begin
              done_q  <= 1'b1;
              resid_q <= '0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_page_seq_chk.sv
module dma_page_seq_chk #(
  parameter int BA_W  = 18,
  parameter int PA_W  = 22,
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             mem_we,
  input logic [1:0]       mem_size,
  input logic [PA_W-1:0]  mem_addr,
  input logic             xl_req,
  input logic             xl_ack,
  input logic [BA_W-1:0]  xl_vaddr,
  input logic             done,
  input logic [CNT_W-1:0] residual
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we));

  p_xl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req && !xl_ack |=> xl_req && $stable(xl_vaddr));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xl_req));

  p_word_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_size == 2'd1 |-> !mem_addr[0]);

  p_long_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_size == 2'd2 |-> mem_addr[1:0] == 2'b00);

  p_size_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !xl_req);

  p_even_resid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !residual[0]);
endmodule

bind dma_page_seq dma_page_seq_chk #(.BA_W(BA_W), .PA_W(PA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_size(mem_size), .mem_addr(mem_addr), .xl_req(xl_req), .xl_ack(xl_ack),
  .xl_vaddr(xl_vaddr), .done(done), .residual(residual)
);

// File: tb/dma_page_seq_test.sv
`timescale 1ns/1ps
module dma_page_seq_test;
  localparam int BA_W = 18, PA_W = 22, CNT_W = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir_wr = 1'b0;
  logic [BA_W-1:0] bus_addr = '0;
  logic [CNT_W-1:0] byte_count = '0;
  logic done;
  logic [CNT_W-1:0] residual;
  logic xl_req, xl_ack = 1'b0, xl_ok = 1'b0;
  logic [BA_W-1:0] xl_vaddr;
  logic [PA_W-1:0] xl_paddr = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [1:0] mem_size;
  logic [PA_W-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [CNT_W-2:0] buf_addr;
  logic buf_we;
  logic [1:0] buf_be;
  logic [15:0] buf_wdata, buf_rdata;

  logic [7:0]  pmem [0:8191];
  logic [15:0] bufm [0:63];
  int  tbl [0:7];
  bit  tvalid [0:7];
  int  n_byte, n_word, n_long, n_xl, n_chk, n_bad;
  logic [PA_W-1:0] addr_log [0:15];
  logic [BA_W-1:0] va_log [0:7];
  logic [CNT_W-1:0] got_resid;
  int  mdly;

  dma_page_seq uut (.*);

  always #2 clk = ~clk;

  assign buf_rdata = bufm[buf_addr[5:0]];

  always @(posedge clk) if (buf_we) begin
    if (buf_be[0]) bufm[buf_addr[5:0]][7:0]  <= buf_wdata[7:0];
    if (buf_be[1]) bufm[buf_addr[5:0]][15:8] <= buf_wdata[15:8];
  end

  // memory responder: one wait cycle, then acknowledge for one cycle
  initial begin
    mdly = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mdly == 0) mdly = 1;
        else begin
          automatic int a = int'(mem_addr[12:0]);
          automatic int nb = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
          mdly = 0;
          if (n_byte + n_word + n_long < 16) addr_log[n_byte + n_word + n_long] = mem_addr;
          if (mem_size == 2'd0) n_byte++; else if (mem_size == 2'd1) n_word++; else n_long++;
          mem_rdata = '0;
          for (int k = 0; k < nb; k++) begin
            if (mem_we) pmem[a + k] = mem_wdata[8*k +: 8];
            else mem_rdata[8*k +: 8] = pmem[a + k];
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  // translation responder
  initial forever begin
    @(negedge clk);
    if (xl_ack) xl_ack = 1'b0;
    else if (xl_req) begin
      automatic int k = int'(xl_vaddr[11:9]);
      if (n_xl < 8) va_log[n_xl] = xl_vaddr;
      n_xl++;
      xl_ok    = tvalid[k];
      xl_paddr = PA_W'((tbl[k] << 9) | int'(xl_vaddr[8:0]));
      xl_ack   = 1'b1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup();
    for (int v = 0; v < 8; v++) begin tbl[v] = v + 2; tvalid[v] = 1'b1; end
    for (int i = 0; i < 8192; i++) pmem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 64; i++) bufm[i] = 16'hA000 + 16'(i * 16'h0111);
    n_byte = 0; n_word = 0; n_long = 0; n_xl = 0;
  endtask

  task automatic run(logic d, logic [BA_W-1:0] ba, logic [CNT_W-1:0] cnt, int poke);
    int cyc;
    bit seen;
    @(negedge clk);
    dir_wr = d; bus_addr = ba; byte_count = cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (cyc = 0; cyc < 2000 && !seen; cyc++) begin
      if (done) begin seen = 1; got_resid = residual; end
      else begin
        if (cyc == poke) begin
          dir_wr = ~d; bus_addr = 18'h100; byte_count = 17'd2; start = 1'b1;
        end else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    if (!seen) begin n_bad++; n_chk++; $display("FAIL R4 transfer timeout actual=0 expected=1"); end
  endtask

  function automatic logic [15:0] w2(int a);
    return {pmem[a + 1], pmem[a]};
  endfunction

  task automatic t_reset();
    chk("R10 reset done", done, 0);
    chk("R8 reset mem_req", mem_req, 0);
    chk("R2 reset xl_req", xl_req, 0);
    chk("R9 reset buf_we", buf_we, 0);
  endtask

  task automatic t_long_read();
    setup();
    run(1'b0, 18'h0, 17'd8, -1);
    chk("R7 long count", n_long, 2);
    chk("R7 no narrow", n_byte + n_word, 0);
    chk("R7 lane low word", bufm[1], w2(12'h402));
    chk("R9 read data", bufm[2], w2(12'h404));
    chk("R4 resid zero", got_resid, 0);
  endtask

  task automatic t_word_read();
    setup();
    run(1'b0, 18'h2, 17'd6, -1);
    chk("R6 word by address", n_word, 3);
    chk("R6 data", bufm[2], w2(12'h406));
    setup();
    run(1'b0, 18'h0, 17'd6, -1);
    chk("R6 word by length", n_word, 3);
    chk("R6 no long", n_long, 0);
  endtask

  task automatic t_byte_read();
    setup();
    run(1'b0, 18'h1, 17'd5, -1);
    chk("R1 count forced even", n_byte, 4);
    chk("R5 pack word0", bufm[0], {pmem[12'h402], pmem[12'h401]});
    chk("R5 pack word1", bufm[1], {pmem[12'h404], pmem[12'h403]});
    chk("R4 resid zero", got_resid, 0);
  endtask

  task automatic t_split_byte();
    setup();
    run(1'b0, 18'h1FD, 17'd4, -1);
    chk("R5 bytes", n_byte, 4);
    chk("R2 two translations", n_xl, 2);
    chk("R2 second vaddr", va_log[1], 18'h200);
    chk("R2 second page addr", addr_log[3], 22'h600);
    chk("R5 parity across chunks", bufm[1], {pmem[12'h600], pmem[12'h5FF]});
  endtask

  task automatic t_page_long();
    setup();
    run(1'b0, 18'h1FC, 17'd12, -1);
    chk("R2 long chunks", n_long, 3);
    chk("R2 translations", n_xl, 2);
    chk("R2 chunk2 start", addr_log[1], 22'h600);
    chk("R7 chunk2 data", bufm[3], w2(12'h602));
  endtask

  task automatic t_fail();
    setup();
    tvalid[1] = 1'b0;
    run(1'b0, 18'h1F8, 17'd20, -1);
    chk("R3 residual", got_resid, 12);
    chk("R3 accesses before fail", n_long, 2);
    setup();
    tvalid[0] = 1'b0;
    run(1'b0, 18'h0, 17'd10, -1);
    chk("R3 first chunk fail", got_resid, 10);
    chk("R3 no access", n_byte + n_word + n_long, 0);
  endtask

  task automatic t_zero();
    setup();
    run(1'b0, 18'h40, 17'd1, -1);
    chk("R4 zero resid", got_resid, 0);
    chk("R4 zero no request", n_xl + n_byte + n_word + n_long, 0);
  endtask

  task automatic t_write();
    logic [15:0] b0, b1, b3;
    setup();
    b0 = bufm[0]; b1 = bufm[1]; b3 = bufm[3];
    run(1'b1, 18'h8, 17'd8, -1);
    chk("R7 write long count", n_long, 2);
    chk("R9 write low", {pmem[12'h409], pmem[12'h408]}, b0);
    chk("R7 write upper lane", {pmem[12'h40B], pmem[12'h40A]}, b1);
    chk("R9 write last", {pmem[12'h40F], pmem[12'h40E]}, b3);
    setup();
    b0 = bufm[0]; b1 = bufm[1];
    run(1'b1, 18'h11, 17'd4, -1);
    chk("R5 write bytes", n_byte, 4);
    chk("R5 write even pos", pmem[12'h411], b0[7:0]);
    chk("R5 write odd pos", pmem[12'h412], b0[15:8]);
    chk("R5 write pos3", pmem[12'h414], b1[15:8]);
    chk("R5 neighbour kept", pmem[12'h415], 8'(12'h415 * 7 + 3));
  endtask

  task automatic t_wrap();
    setup();
    run(1'b0, 18'h3FFFC, 17'd8, -1);
    chk("R2 wrap vaddr", va_log[1], 18'h0);
    chk("R2 wrap first pa", addr_log[0], 22'h13FC);
    chk("R2 wrap second pa", addr_log[1], 22'h400);
  endtask

  task automatic t_busy_start();
    setup();
    run(1'b0, 18'h1FC, 17'd12, 9);
    chk("R1 busy start ignored count", n_long, 3);
    chk("R1 busy start xl", n_xl, 2);
    chk("R1 busy start data", bufm[3], w2(12'h602));
    chk("R1 busy start resid", got_resid, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    setup();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_long_read();
    t_word_read();
    t_byte_read();
    t_split_byte();
    t_page_long();
    t_fail();
    t_zero();
    t_write();
    t_wrap();
    t_busy_start();
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule